// File: doc/BRIEF.md
# Calibrated RTC Second Prescaler with Frequency Test Output

This block turns a 32,768 Hz oscillator enable into a one-second tick and a minute tick for a real-time clock. The oscillator arrives as a one-cycle enable `osc_tick_i` in the fast system clock domain. The prescaler has two stages: a low stage that divides by 256 and a high stage that divides by 128. Digital calibration corrects crystal error. Over a repeating 64-minute cycle, the first second of some early minutes is made shorter or longer. The low stage is where that correction is applied.

A signed code sets the calibration. A 5-bit magnitude N selects how many minutes are affected: the first 2·N minutes of the cycle, and never more than 62. A sign bit selects the direction:

- When the sign bit is 1, the clock runs faster. The affected second is 256 oscillator ticks short, because one whole low-stage period is skipped.
- When the sign bit is 0, the clock runs slower. The affected second is 128 ticks long, because the first low-stage period of that second is stretched by half.

The code is captured only at the start of each 64-minute cycle. A cycle therefore never runs with a mixed correction.

A manufacturing test output gives a 512 Hz square wave. It is taken from its own counter of raw oscillator ticks, so calibration never changes its rate. It is an active-low pull-down enable for an open-drain pin. The register file that owns the frequency-test bit clears that bit at power-up, so the pin starts released.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: During and straight after reset (`rst_ni` low, then released with no oscillator tick), `sec_tick_o` and `min_tick_o` are 0 and `ft_od_n_o` is 1 (released). The divider, the second counter, the minute counter and the cycle counter all restart at 0.
- R2: With no adjustment active, a second lasts exactly LO_DIV·HI_DIV oscillator ticks (32,768 by default). `sec_tick_o` is a one-cycle pulse in the clock cycle after the edge that takes the tick ending the second.
- R3: `min_tick_o` pulses in the same cycle as every SEC_PER_MIN-th (60th) second pulse, and at no other time.
- R4: With the sign bit at 1 and a magnitude N other than 0, the first second of each of minutes 0 to min(2·N, ELIG_MIN)−1 of the 64-minute cycle lasts LO_DIV fewer ticks (32,512).
- R5: With the sign bit at 0 and a magnitude N other than 0, those same seconds last LO_DIV/2 more ticks (32,896).
- R6: A magnitude of 0 gives no adjustment for either sign. Seconds other than the first of a minute, and minutes at index min(2·N, ELIG_MIN) or above, are never adjusted.
- R7: The calibration inputs are captured on the first non-stopped oscillator tick after reset, and on the tick that completes the last minute of each cycle. Changes at any other time have no effect until the next capture.
- R8: While `stop_i` is 1, oscillator ticks are ignored. Every counter holds its value, and no second or minute pulse is produced.
- R9: The test output is enabled when `stop_i`=0, `ftest_i`=1, `afe_i`=0, and either `wd_steer_i`=1 or `wd_zero_i`=1. Phase p is the number of non-stopped ticks since reset, taken modulo 2·FT_HALF (64). When enabled, `ft_od_n_o` is 0 while p ≥ FT_HALF and 1 otherwise. When disabled, it is 1.
- R10: The phase and period of the test output do not depend on the calibration magnitude or sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | One-cycle enable per oscillator period |
| cal_mag_i | input | 5 | Calibration magnitude N |
| cal_pos_i | input | 1 | Calibration sign, 1 = speed up, 0 = slow down |
| stop_i | input | 1 | Oscillator stop, freezes the prescaler |
| ftest_i | input | 1 | Frequency-test request |
| afe_i | input | 1 | Alarm flag enable, blocks the test output |
| wd_steer_i | input | 1 | Watchdog steering bit |
| wd_zero_i | input | 1 | Watchdog register is zero |
| sec_tick_o | output | 1 | One-second pulse |
| min_tick_o | output | 1 | One-minute pulse |
| ft_od_n_o | output | 1 | Active-low pull-down enable for the 512 Hz test pin |

## Verification
The hardest coincidence is a calibration write that lands on the very oscillator tick that closes the last minute of a cycle. On that tick the capture and the minute wrap happen on the same edge.

The bench predicts when the next tick will end the cycle. Half of those times, it changes the magnitude and sign for exactly that tick.

The bench then measures the length of every second in the new cycle against a model. That model captures the code present during the closing tick. A one-tick error in capture timing shows up as a wrong second length in minute 0.

The test output is checked on the same samples. This includes samples where its edges fall together with second pulses and stretched periods.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned CAL_MAG_W = 5;

  typedef struct packed {
    logic                 pos;
    logic [CAL_MAG_W-1:0] mag;
  } cal_t;
endpackage

// File: rtl/rtc_sec_div.sv
module rtc_sec_div #(
  parameter int unsigned LO_DIV = 256,
  parameter int unsigned HI_DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic stop_i,
  input  logic adj_short_i,
  input  logic adj_long_i,
  output logic sec_end_o
);
  localparam int unsigned LO_EXT = LO_DIV + LO_DIV / 2;
  localparam int unsigned LO_W   = $clog2(LO_EXT);
  localparam int unsigned HI_W   = $clog2(HI_DIV);

  logic [LO_W-1:0] lo_q, lo_top;
  logic [HI_W-1:0] hi_q, hi_step;
  logic            tick, first_lo, lo_carry, hi_last;

  assign tick     = osc_tick_i & ~stop_i;
  assign first_lo = (hi_q == '0);
  // slow-down: stretch first low period of the second by half
  assign lo_top   = (first_lo && adj_long_i) ? LO_W'(LO_EXT - 1) : LO_W'(LO_DIV - 1);
  assign lo_carry = tick && (lo_q == lo_top);
  // speed-up: skip one low period
  assign hi_step  = (first_lo && adj_short_i) ? HI_W'(2) : HI_W'(1);
  assign hi_last  = (hi_q == HI_W'(HI_DIV - 1));
  assign sec_end_o = lo_carry && hi_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (tick) begin
      lo_q <= lo_carry ? '0 : lo_q + LO_W'(1);
      if (lo_carry) hi_q <= hi_last ? '0 : hi_q + hi_step;
    end
  end

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> ($stable(lo_q) && $stable(hi_q))); // R8
  AST_STRETCH_ONLY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_q > LO_W'(LO_DIV - 1)) |-> (first_lo && adj_long_i)); // R5
endmodule

// File: rtl/rtc_cal_sched.sv
module rtc_cal_sched
  import rtc_cal_pkg::*;
#(
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned MIN_PER_CYC = 64,
  parameter int unsigned ELIG_MIN    = 62
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sec_end_i,
  input  cal_t cal_i,
  output logic adj_short_o,
  output logic adj_long_o,
  output logic sec_tick_o,
  output logic min_tick_o
);
  localparam int unsigned SEC_W = $clog2(SEC_PER_MIN);
  localparam int unsigned MIN_W = $clog2(MIN_PER_CYC);
  localparam int unsigned LIM_W = MIN_W + CAL_MAG_W + 2;

  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  cal_t             cal_q, cal_eff;
  logic             load_pend_q;
  logic             last_sec, last_min, cyc_wrap, eligible;
  logic [LIM_W-1:0] two_n, elig_lim, lim;

  assign cal_eff  = load_pend_q ? cal_i : cal_q;
  assign last_sec = (sec_q == SEC_W'(SEC_PER_MIN - 1));
  assign last_min = (min_q == MIN_W'(MIN_PER_CYC - 1));
  assign cyc_wrap = sec_end_i && last_sec && last_min;

  assign two_n    = LIM_W'({cal_eff.mag, 1'b0});
  assign elig_lim = LIM_W'(ELIG_MIN);
  assign lim      = (two_n < elig_lim) ? two_n : elig_lim;
  assign eligible = (sec_q == '0) && (LIM_W'(min_q) < lim);

  assign adj_short_o = eligible &&  cal_eff.pos;
  assign adj_long_o  = eligible && !cal_eff.pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q       <= '0;
      min_q       <= '0;
      cal_q       <= '0;
      load_pend_q <= 1'b1;
      sec_tick_o  <= 1'b0;
      min_tick_o  <= 1'b0;
    end else begin
      sec_tick_o <= sec_end_i;
      min_tick_o <= sec_end_i && last_sec;
      if (tick_i && load_pend_q) begin
        load_pend_q <= 1'b0;
        cal_q       <= cal_i;
      end
      if (sec_end_i) begin
        sec_q <= last_sec ? '0 : sec_q + SEC_W'(1);
        if (last_sec) min_q <= last_min ? '0 : min_q + MIN_W'(1);
      end
      if (cyc_wrap) cal_q <= cal_i;
    end
  end

  AST_MIN_WITH_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_tick_o |-> sec_tick_o); // R3
  AST_MIN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_tick_o |=> !min_tick_o); // R3
  AST_CAL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_wrap && !(load_pend_q && tick_i)) |=> $stable(cal_q)); // R7
endmodule

// File: rtl/rtc_ftest_gen.sv
module rtc_ftest_gen #(
  parameter int unsigned FT_HALF = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic stop_i,
  input  logic ftest_i,
  input  logic afe_i,
  input  logic wd_steer_i,
  input  logic wd_zero_i,
  output logic ft_od_n_o
);
  localparam int unsigned FT_PER = 2 * FT_HALF;
  localparam int unsigned FT_W   = $clog2(FT_PER);

  logic [FT_W-1:0] ft_q;
  logic            tick, ft_en, ft_last;

  assign tick    = osc_tick_i & ~stop_i;
  assign ft_last = (ft_q == FT_W'(FT_PER - 1));
  assign ft_en   = ~stop_i & ftest_i & ~afe_i & (wd_steer_i | wd_zero_i);
  assign ft_od_n_o = ~(ft_en && (ft_q >= FT_W'(FT_HALF)));

  // raw tick counter, ahead of any calibration
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ft_q <= '0;
    else if (tick) ft_q <= ft_last ? '0 : ft_q + FT_W'(1);
  end

  AST_FT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> $stable(ft_q)); // R8
endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int unsigned LO_DIV      = 256,
  parameter int unsigned HI_DIV      = 128,
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned MIN_PER_CYC = 64,
  parameter int unsigned ELIG_MIN    = 62,
  parameter int unsigned FT_HALF     = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 osc_tick_i,
  input  logic [CAL_MAG_W-1:0] cal_mag_i,
  input  logic                 cal_pos_i,
  input  logic                 stop_i,
  input  logic                 ftest_i,
  input  logic                 afe_i,
  input  logic                 wd_steer_i,
  input  logic                 wd_zero_i,
  output logic                 sec_tick_o,
  output logic                 min_tick_o,
  output logic                 ft_od_n_o
);
  cal_t cal;
  logic adj_short, adj_long, sec_end, tick;

  assign cal.pos = cal_pos_i;
  assign cal.mag = cal_mag_i;
  assign tick    = osc_tick_i & ~stop_i;

  rtc_sec_div #(.LO_DIV(LO_DIV), .HI_DIV(HI_DIV)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .osc_tick_i  (osc_tick_i),
    .stop_i      (stop_i),
    .adj_short_i (adj_short),
    .adj_long_i  (adj_long),
    .sec_end_o   (sec_end)
  );

  rtc_cal_sched #(
    .SEC_PER_MIN (SEC_PER_MIN),
    .MIN_PER_CYC (MIN_PER_CYC),
    .ELIG_MIN    (ELIG_MIN)
  ) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .sec_end_i   (sec_end),
    .cal_i       (cal),
    .adj_short_o (adj_short),
    .adj_long_o  (adj_long),
    .sec_tick_o  (sec_tick_o),
    .min_tick_o  (min_tick_o)
  );

  rtc_ftest_gen #(.FT_HALF(FT_HALF)) u_ft (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_tick_i (osc_tick_i),
    .stop_i     (stop_i),
    .ftest_i    (ftest_i),
    .afe_i      (afe_i),
    .wd_steer_i (wd_steer_i),
    .wd_zero_i  (wd_zero_i),
    .ft_od_n_o  (ft_od_n_o)
  );

  AST_NO_TICK_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sec_tick_o); // R8
endmodule

// File: tb/rtc_cal_prescaler_tb.sv
module rtc_cal_prescaler_tb;
  localparam int LO = 8, HI = 4, SPM = 4, MPC = 8, ELIG = 6, FTH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc = 1'b0, cal_pos = 1'b1, stop = 1'b0;
  logic ftest = 1'b0, afe = 1'b0, wd_steer = 1'b0, wd_zero = 1'b0;
  logic [4:0] cal_mag = 5'd0;
  logic sec_tick, min_tick, ft_od_n;

  int checks = 0, fails = 0;
  bit done = 0;
  // bench model
  int cnt = 0, sec_idx = 0, min_idx = 0, ph = 0;
  int lat_mag = 0, lat_pos = 0;
  bit pend = 1, exp_sec = 0, exp_min = 0;
  string sec_tag;

  always #4 clk = ~clk;

  rtc_cal_prescaler #(
    .LO_DIV(LO), .HI_DIV(HI), .SEC_PER_MIN(SPM), .MIN_PER_CYC(MPC),
    .ELIG_MIN(ELIG), .FT_HALF(FTH)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc), .cal_mag_i(cal_mag),
    .cal_pos_i(cal_pos), .stop_i(stop), .ftest_i(ftest), .afe_i(afe),
    .wd_steer_i(wd_steer), .wd_zero_i(wd_zero), .sec_tick_o(sec_tick),
    .min_tick_o(min_tick), .ft_od_n_o(ft_od_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input int s, input int m, input int mag, input int pos);
    int lim;
    lim = (2 * mag < ELIG) ? 2 * mag : ELIG;
    if (s == 0 && m < lim) return pos ? LO * HI - LO : LO * HI + LO / 2;
    return LO * HI;
  endfunction

  function automatic string len_tag(input int s, input int m, input int mag, input int pos);
    int lim;
    lim = (2 * mag < ELIG) ? 2 * mag : ELIG;
    if (mag == 0 || s != 0 || m >= lim) return (mag == 0 && s == 0) ? "R6" : "R2";
    return pos ? "R4" : "R5";
  endfunction

  function automatic bit ft_en();
    return !stop && ftest && !afe && (wd_steer || wd_zero);
  endfunction

  // one clock: inputs already set at negedge
  task automatic step(input bit o);
    bit ticked;
    osc = o;
    ticked = o && !stop;
    @(posedge clk);
    exp_sec = 0; exp_min = 0;
    if (ticked) begin
      if (pend) begin lat_mag = cal_mag; lat_pos = cal_pos; pend = 0; end
      ph = (ph + 1) % (2 * FTH);
      cnt++;
      if (cnt == exp_len(sec_idx, min_idx, lat_mag, lat_pos)) begin
        sec_tag = len_tag(sec_idx, min_idx, lat_mag, lat_pos);
        if (lat_mag != cal_mag || lat_pos != cal_pos) sec_tag = "R7";
        exp_sec = 1; cnt = 0;
        exp_min = (sec_idx == SPM - 1);
        if (sec_idx == SPM - 1) begin
          sec_idx = 0;
          if (min_idx == MPC - 1) begin
            min_idx = 0; lat_mag = cal_mag; lat_pos = cal_pos;
          end else min_idx++;
        end else sec_idx++;
      end
    end
    @(negedge clk);
    osc = 0;
    if (o && stop) begin
      chk(sec_tick == 0, "R8 stopped sec", sec_tick, 0);
    end else if (exp_sec) begin
      chk(sec_tick == 1, sec_tag, sec_tick, 1);
    end else begin
      chk(sec_tick == 0, "R2 no pulse", sec_tick, 0);
    end
    chk(min_tick == exp_min, "R3 minute", min_tick, exp_min);
    chk(ft_od_n == !(ft_en() && ph >= FTH), (cal_mag != 0) ? "R10 ftest" : "R9 ftest",
        ft_od_n, !(ft_en() && ph >= FTH));
  endtask

  function automatic bit next_wraps();
    return !stop && sec_idx == SPM - 1 && min_idx == MPC - 1 &&
           cnt + 1 == exp_len(sec_idx, min_idx, lat_mag, lat_pos);
  endfunction

  task automatic run(input int n, input int stop_pct, input int cal_pct,
                     input int gate_pct, input bit hit_wrap);
    for (int i = 0; i < n; i++) begin
      if (($urandom % 100) < stop_pct) stop = 1; else stop = 0;
      if (($urandom % 1000) < cal_pct) begin
        cal_mag = 5'($urandom % 32); cal_pos = 1'($urandom % 2);
      end
      if (($urandom % 100) < gate_pct) begin
        {ftest, afe, wd_steer, wd_zero} = 4'($urandom);
      end
      if (hit_wrap && next_wraps() && ($urandom % 2 == 1)) begin
        cal_mag = 5'($urandom % 32); cal_pos = 1'($urandom % 2);
      end
      step(1);
      for (int g = 0; g < int'($urandom % 3); g++) step(0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(sec_tick == 0 && min_tick == 0, "R1 reset ticks", sec_tick, 0);
    chk(ft_od_n == 1, "R1 reset ft", ft_od_n, 1);
    rst_n = 1;
    @(negedge clk);
    chk(sec_tick == 0 && min_tick == 0, "R1 post-reset ticks", min_tick, 0);
    chk(ft_od_n == 1, "R1 post-reset ft", ft_od_n, 1);
    // zero magnitude, test output on
    ftest = 1; wd_steer = 1;
    run(2100, 0, 0, 0, 0);
    // positive, written mid-cycle
    cal_mag = 5'd1; cal_pos = 1;
    run(2100, 0, 0, 0, 0);
    // negative full scale, clamped
    cal_mag = 5'd31; cal_pos = 0;
    run(2100, 5, 0, 0, 0);
    // negative 2 with gate changes
    cal_mag = 5'd2; cal_pos = 0; wd_steer = 0; wd_zero = 1;
    run(2100, 0, 0, 5, 0);
    // random mix with writes on cycle wraps
    run(6000, 10, 5, 2, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule